// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block arbitrates 60 external interrupt lines for a processor core. Software programs it through a small word-addressed register port. Each line has an enable bit and a pending bit, and each has a 4-bit priority that sits in the upper half of a byte. A 3-bit grouping code splits every priority into a preemption part and a sub-priority part. The grouping code can only be written together with a key.

In every cycle the arbiter picks the best line among those that are both enabled and pending. It raises a request to the core only if that line's preemption part beats the handler that is running now. When the core accepts the request, the line's pending bit clears and its priority is pushed onto a stack of active handlers. An exception-return pulse pops that stack. The top of the stack sets the current preemption threshold. There is no threshold when the stack is empty.

Registers use word addresses. Each of these regions holds 8 words:
- set-enable at 0x00
- clear-enable at 0x08
- set-pending at 0x10
- clear-pending at 0x18

Line n sits in word n/32 of its region, at bit n%32. The priority words run from 0x20 to 0x3F and hold four lines per word. The control word is at 0x40.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, all enable bits, pending bits, priorities and the grouping code are 0. `irq_req` is 0, `nest_depth` is 0, and every register reads 0.
- R2: A write to the set-enable word enables each line whose data bit is 1. A write to the clear-enable word disables each line whose data bit is 1. Zero bits leave lines unchanged. Reading the set word or the clear word returns the current enables. Bits for lines 60 and above read 0.
- R3: The pending set word and clear word behave the same way on the pending bits. If set-pending and an accepted take hit the same line in one cycle, the set wins.
- R4: A write to priority word k (address 0x20+k) loads line 4k+j from data bits [8j+7:8j+4]. Bits [8j+3:8j] of the read value are always 0.
- R5: The control word holds the grouping code at bits [10:8]. A write changes the code only if bits [31:16] of the same write equal 0x05FA. All other control bits read 0.
- R6: The candidate lines are those that are both enabled and pending. The winner is the candidate with the smallest 4-bit priority. When priorities are equal, the lowest line number wins.
- R7: `irq_req` is 1 when a winner exists and either the stack is empty or the winner's preemption part is smaller than that of the stack top. The number of sub-priority bits is 0, 1, 2, 3 or 4 for codes 011, 100, 101, 110 and 111. Codes 000 to 010 act as 011.
- R8: A change of grouping code changes the preemption comparison from the next cycle on. The comparison uses the stored priorities, including the priorities already on the stack.
- R9: `take_ack` together with `irq_req` and no `exc_ret` clears the winner's pending bit and increments `nest_depth`. `exc_ret` decrements a non-zero depth. `exc_ret` at depth 0 does nothing. `exc_ret` together with `take_ack` leaves the pending bits unchanged and only pops.
- R10: `take_ack` while `irq_req` is 0 changes neither the pending bits nor the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| take_ack | input | 1 | Core accepts the requested line |
| exc_ret | input | 1 | Handler return pulse, pops one nesting level |
| irq_req | output | 1 | Request to take the line on `irq_line` |
| irq_line | output | 6 | Winning line number, valid while `irq_req` is 1 |
| nest_depth | output | 5 | Number of active nested handlers |

## Verification
The bench builds the block with its default values:
- 60 lines, so the top enable and pending words are only partly populated.
- 4 priority bits, which allows all five grouping codes and up to sixteen nested levels.

Directed steps cover these cases:
- a priority tie broken by line number
- a disabled pending line with the best priority, which must not win
- a control write with a wrong key
- a regrouping that turns a blocked line into a preempting one
- simultaneous take and return

A random phase then mixes register writes, takes and returns. A behavioural model checks every cycle and every read.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [15:0]       GRP_KEY   = 16'h05FA;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h40;

  typedef enum logic [2:0] {
    RG_EN_SET = 3'd0,
    RG_EN_CLR = 3'd1,
    RG_PD_SET = 3'd2,
    RG_PD_CLR = 3'd3,
    RG_PRIO   = 3'd4,
    RG_CTRL   = 3'd5,
    RG_NONE   = 3'd6
  } region_e;

  function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
    region_e r;
    if (a[7:5] == 3'b000) begin
      case (a[4:3])
        2'd0:    r = RG_EN_SET;
        2'd1:    r = RG_EN_CLR;
        2'd2:    r = RG_PD_SET;
        default: r = RG_PD_CLR;
      endcase
    end else if (a[7:5] == 3'b001) begin
      r = RG_PRIO;
    end else if (a == CTRL_ADDR) begin
      r = RG_CTRL;
    end else begin
      r = RG_NONE;
    end
    return r;
  endfunction

  // Number of sub-priority bits for a grouping code; codes below 3 act as 3.
  function automatic int unsigned sub_bits(input logic [2:0] code, input int unsigned pbits);
    int unsigned c;
    int unsigned s;
    c = (code < 3'd3) ? 3 : int'(code);
    s = c - 3;
    if (s > pbits) s = pbits;
    return s;
  endfunction

endpackage

// File: rtl/irqarb_regs.sv
module irqarb_regs
  import irqarb_pkg::*;
#(
  parameter int NUM_LINES = 60,
  parameter int PRIO_BITS = 4,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bus_wr,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic [BUS_W-1:0]                     bus_wdata,
  input  logic                                 take_fire,
  input  logic [LINE_W-1:0]                    take_line,
  output logic [NUM_LINES-1:0]                 en_q,
  output logic [NUM_LINES-1:0]                 pend_q,
  output logic [NUM_LINES-1:0][PRIO_BITS-1:0]  prio_q,
  output logic [2:0]                           group_q,
  output logic [BUS_W-1:0]                     bus_rdata
);

  localparam int NW = (NUM_LINES + 31) / 32;
  localparam int PW = (NUM_LINES + 3) / 4;

  region_e                               rg;
  logic [2:0]                            wsel_s;
  logic [4:0]                            wsel_p;
  logic [NUM_LINES-1:0]                  en_set, en_clr, pd_set, pd_clr, take_hit;
  logic [NUM_LINES-1:0]                  prio_we;
  logic [NUM_LINES-1:0][PRIO_BITS-1:0]   prio_d;
  logic [NUM_LINES-1:0]                  en_d, pend_d;
  logic [NUM_LINES*8-1:0]                prio_bytes;
  logic [NW*32-1:0]                      en_pad, pend_pad;
  logic [PW*32-1:0]                      prio_pad;
  logic                                  grp_we;

  assign rg     = decode_region(bus_addr);
  assign wsel_s = bus_addr[2:0];
  assign wsel_p = bus_addr[4:0];

  // Per-line write decode and priority storage.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int WI  = i / 32;
    localparam int BI  = i % 32;
    localparam int PWI = i / 4;
    localparam int LO  = 8 * (i % 4) + 8 - PRIO_BITS;

    assign en_set[i]   = bus_wr && (rg == RG_EN_SET) && (wsel_s == 3'(WI)) && bus_wdata[BI];
    assign en_clr[i]   = bus_wr && (rg == RG_EN_CLR) && (wsel_s == 3'(WI)) && bus_wdata[BI];
    assign pd_set[i]   = bus_wr && (rg == RG_PD_SET) && (wsel_s == 3'(WI)) && bus_wdata[BI];
    assign pd_clr[i]   = bus_wr && (rg == RG_PD_CLR) && (wsel_s == 3'(WI)) && bus_wdata[BI];
    assign take_hit[i] = take_fire && (take_line == LINE_W'(i));
    assign prio_we[i]  = bus_wr && (rg == RG_PRIO) && (wsel_p == 5'(PWI));
    assign prio_d[i]   = bus_wdata[LO +: PRIO_BITS];
    assign prio_bytes[8*i +: 8] = {prio_q[i], {(8-PRIO_BITS){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[i] <= '0;
      end else if (prio_we[i]) begin
        prio_q[i] <= prio_d[i];
      end
    end
  end

  // Next state of enable and pending vectors.
  always_comb begin
    en_d   = (en_q | en_set) & ~en_clr;
    pend_d = (pend_q & ~pd_clr & ~take_hit) | pd_set;
  end

  assign grp_we = bus_wr && (rg == RG_CTRL) && (bus_wdata[31:16] == GRP_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pend_q  <= '0;
      group_q <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      if (grp_we) begin
        group_q <= bus_wdata[10:8];
      end
    end
  end

  // Read path.
  always_comb begin
    en_pad   = '0;
    pend_pad = '0;
    prio_pad = '0;
    en_pad[NUM_LINES-1:0]     = en_q;
    pend_pad[NUM_LINES-1:0]   = pend_q;
    prio_pad[NUM_LINES*8-1:0] = prio_bytes;
  end

  always_comb begin
    bus_rdata = '0;
    case (rg)
      RG_EN_SET, RG_EN_CLR: begin
        if (int'(wsel_s) < NW) bus_rdata = en_pad[32*int'(wsel_s) +: 32];
      end
      RG_PD_SET, RG_PD_CLR: begin
        if (int'(wsel_s) < NW) bus_rdata = pend_pad[32*int'(wsel_s) +: 32];
      end
      RG_PRIO: begin
        if (int'(wsel_p) < PW) bus_rdata = prio_pad[32*int'(wsel_p) +: 32];
      end
      RG_CTRL: bus_rdata[10:8] = group_q;
      default: bus_rdata = '0;
    endcase
  end

  // A control write without the key must not move the grouping code.
  p_key_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_ADDR && bus_wdata[31:16] != GRP_KEY) |=> $stable(group_q));

  // A taken line loses its pending bit unless software sets it in the same cycle.
  p_take_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fire && !pd_set[take_line]) |=> !pend_q[$past(take_line)]);

endmodule

// File: rtl/irqarb_select.sv
module irqarb_select #(
  parameter int NUM_LINES = 60,
  parameter int PRIO_BITS = 4,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]                 en_q,
  input  logic [NUM_LINES-1:0]                 pend_q,
  input  logic [NUM_LINES-1:0][PRIO_BITS-1:0]  prio_q,
  output logic                                 win_valid,
  output logic [LINE_W-1:0]                    win_line,
  output logic [PRIO_BITS-1:0]                 win_prio
);

  logic [NUM_LINES-1:0] cand;

  assign cand = en_q & pend_q;

  // Strict comparison while scanning upward keeps the lowest line on ties.
  always_comb begin
    win_valid = 1'b0;
    win_line  = '0;
    win_prio  = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!win_valid || (prio_q[i] < win_prio))) begin
        win_valid = 1'b1;
        win_line  = LINE_W'(i);
        win_prio  = prio_q[i];
      end
    end
  end

endmodule

// File: rtl/irqarb_nest.sv
module irqarb_nest
  import irqarb_pkg::*;
#(
  parameter int PRIO_BITS  = 4,
  parameter int NEST_DEPTH = 1 << PRIO_BITS,
  parameter int DEPTH_W    = $clog2(NEST_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            group_q,
  input  logic                  win_valid,
  input  logic [PRIO_BITS-1:0]  win_prio,
  input  logic                  take_ack,
  input  logic                  exc_ret,
  output logic                  irq_req,
  output logic                  take_fire,
  output logic [DEPTH_W-1:0]    depth_q
);

  localparam int IDX_W = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1;

  logic [PRIO_BITS-1:0] stk_q [NEST_DEPTH];
  logic [PRIO_BITS-1:0] top_prio;
  logic [PRIO_BITS-1:0] pre_mask;
  logic [DEPTH_W-1:0]   depth_d;
  logic [IDX_W-1:0]     push_idx, top_idx;
  logic                 stk_empty, do_pop;
  int unsigned          nsub;

  assign stk_empty = (depth_q == '0);
  assign push_idx  = IDX_W'(depth_q);
  assign top_idx   = IDX_W'(depth_q - DEPTH_W'(1));
  assign top_prio  = stk_q[top_idx];

  // Preemption mask: clear the sub-priority bits chosen by the grouping code.
  always_comb begin
    nsub     = sub_bits(group_q, PRIO_BITS);
    pre_mask = '1;
    for (int b = 0; b < PRIO_BITS; b++) begin
      if (b < int'(nsub)) pre_mask[b] = 1'b0;
    end
  end

  always_comb begin
    irq_req   = win_valid && (stk_empty || ((win_prio & pre_mask) < (top_prio & pre_mask)));
    take_fire = irq_req && take_ack && !exc_ret;
    do_pop    = exc_ret && !stk_empty;
    depth_d   = depth_q;
    if (do_pop)         depth_d = depth_q - DEPTH_W'(1);
    else if (take_fire) depth_d = depth_q + DEPTH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else begin
      depth_q <= depth_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take_fire) begin
      stk_q[push_idx] <= win_prio;
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |-> (depth_q < DEPTH_W'(NEST_DEPTH)));

  p_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |=> (depth_q == $past(depth_q) + DEPTH_W'(1)));

  p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret && depth_q != '0) |=> (depth_q == $past(depth_q) - DEPTH_W'(1)));

  p_exc_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret && depth_q == '0) |=> (depth_q == '0));

  p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ack && !irq_req && !exc_ret) |=> $stable(depth_q));

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irqarb_pkg::*;
#(
  parameter int NUM_LINES = 60,
  parameter int PRIO_BITS = 4,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int DEPTH_W   = $clog2((1 << PRIO_BITS) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                take_ack,
  input  logic                exc_ret,
  output logic                irq_req,
  output logic [LINE_W-1:0]   irq_line,
  output logic [DEPTH_W-1:0]  nest_depth
);

  localparam int NEST_DEPTH = 1 << PRIO_BITS;

  logic                                 rst_meta, rst_s;
  logic [NUM_LINES-1:0]                 en_q, pend_q;
  logic [NUM_LINES-1:0][PRIO_BITS-1:0]  prio_q;
  logic [2:0]                           group_q;
  logic                                 win_valid, take_fire;
  logic [LINE_W-1:0]                    win_line;
  logic [PRIO_BITS-1:0]                 win_prio;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  irqarb_regs #(
    .NUM_LINES (NUM_LINES),
    .PRIO_BITS (PRIO_BITS),
    .LINE_W    (LINE_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .take_fire (take_fire),
    .take_line (win_line),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .prio_q    (prio_q),
    .group_q   (group_q),
    .bus_rdata (bus_rdata)
  );

  irqarb_select #(
    .NUM_LINES (NUM_LINES),
    .PRIO_BITS (PRIO_BITS),
    .LINE_W    (LINE_W)
  ) u_select (
    .en_q      (en_q),
    .pend_q    (pend_q),
    .prio_q    (prio_q),
    .win_valid (win_valid),
    .win_line  (win_line),
    .win_prio  (win_prio)
  );

  irqarb_nest #(
    .PRIO_BITS  (PRIO_BITS),
    .NEST_DEPTH (NEST_DEPTH),
    .DEPTH_W    (DEPTH_W)
  ) u_nest (
    .clk       (clk),
    .rst_n     (rst_s),
    .group_q   (group_q),
    .win_valid (win_valid),
    .win_prio  (win_prio),
    .take_ack  (take_ack),
    .exc_ret   (exc_ret),
    .irq_req   (irq_req),
    .take_fire (take_fire),
    .depth_q   (nest_depth)
  );

  assign irq_line = win_line;

  // The requested line must be enabled and pending in the register file.
  p_req_is_cand_r6: assert property (@(posedge clk) disable iff (!rst_s)
    irq_req |-> (en_q[irq_line] && pend_q[irq_line]));

endmodule

// File: tb/irq_prio_arbiter_test.sv
`timescale 1ns/1ps
module irq_prio_arbiter_test;

  localparam int NL = 60;
  localparam int NW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        take_ack = 1'b0;
  logic        exc_ret = 1'b0;
  logic        irq_req;
  logic [5:0]  irq_line;
  logic [4:0]  nest_depth;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 0;

  // Behavioural model state.
  bit m_en [NL];
  bit m_pd [NL];
  int m_pr [NL];
  int m_grp;
  int m_stk [$];

  always #10 clk = ~clk;

  irq_prio_arbiter uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .take_ack(take_ack),
    .exc_ret(exc_ret), .irq_req(irq_req), .irq_line(irq_line),
    .nest_depth(nest_depth)
  );

  function automatic void chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endfunction

  function automatic int m_mask();
    int c;
    c = (m_grp < 3) ? 3 : m_grp;
    return (15 << (c - 3)) & 15;
  endfunction

  function automatic void m_eval(output bit req, output int line);
    int best;
    best = -1;
    for (int i = 0; i < NL; i++)
      if (m_en[i] && m_pd[i] && (best < 0 || m_pr[i] < m_pr[best])) best = i;
    line = best;
    req  = 0;
    if (best >= 0) begin
      if (m_stk.size() == 0) req = 1;
      else req = ((m_pr[best] & m_mask()) < (m_stk[$] & m_mask()));
    end
  endfunction

  function automatic void m_write(int a, logic [31:0] d);
    if (a < 8 && a < NW) begin
      for (int b = 0; b < 32; b++) if (a*32+b < NL && d[b]) m_en[a*32+b] = 1;
    end else if (a >= 8 && a < 8+NW) begin
      for (int b = 0; b < 32; b++) if ((a-8)*32+b < NL && d[b]) m_en[(a-8)*32+b] = 0;
    end else if (a >= 16 && a < 16+NW) begin
      for (int b = 0; b < 32; b++) if ((a-16)*32+b < NL && d[b]) m_pd[(a-16)*32+b] = 1;
    end else if (a >= 24 && a < 24+NW) begin
      for (int b = 0; b < 32; b++) if ((a-24)*32+b < NL && d[b]) m_pd[(a-24)*32+b] = 0;
    end else if (a >= 32 && a < 64) begin
      for (int k = 0; k < 4; k++) if ((a-32)*4+k < NL) m_pr[(a-32)*4+k] = int'((d >> (8*k+4)) & 32'hF);
    end else if (a == 64 && d[31:16] == 16'h05FA) begin
      m_grp = int'(d[10:8]);
    end
  endfunction

  function automatic logic [31:0] m_read(int a);
    logic [31:0] v;
    v = '0;
    if (a < 16 && (a % 8) < NW) begin
      for (int b = 0; b < 32; b++) if ((a%8)*32+b < NL) v[b] = m_en[(a%8)*32+b];
    end else if (a >= 16 && a < 32 && (a % 8) < NW) begin
      for (int b = 0; b < 32; b++) if ((a%8)*32+b < NL) v[b] = m_pd[(a%8)*32+b];
    end else if (a >= 32 && a < 64) begin
      for (int k = 0; k < 4; k++) if ((a-32)*4+k < NL) v[8*k+4 +: 4] = 4'(m_pr[(a-32)*4+k]);
    end else if (a == 64) begin
      v[10:8] = 3'(m_grp);
    end
    return v;
  endfunction

  // Model update on every edge, from the state before the edge.
  always @(posedge clk) begin
    bit rq;
    int ln;
    bit fire;
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin m_en[i] = 0; m_pd[i] = 0; m_pr[i] = 0; end
      m_grp = 0;
      m_stk.delete();
    end else begin
      m_eval(rq, ln);
      fire = take_ack && rq && !exc_ret;
      if (exc_ret && m_stk.size() > 0) void'(m_stk.pop_back());
      if (fire) begin
        m_stk.push_back(m_pr[ln]);
        m_pd[ln] = 0;
      end
      if (bus_wr) m_write(int'(bus_addr), bus_wdata);
    end
  end

  // Per-cycle comparison of the core-side outputs (R6, R7, R9).
  always @(negedge clk) begin
    bit rq;
    int ln;
    if (chk_on) begin
      m_eval(rq, ln);
      chk(irq_req == rq, "R7 irq_req vs model", irq_req, rq);
      if (rq) chk(int'(irq_line) == ln, "R6 irq_line vs model", irq_line, ln);
      chk(int'(nest_depth) == m_stk.size(), "R9 nest_depth vs model", nest_depth, m_stk.size());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic pulse(input bit tk, input bit ex);
    @(negedge clk);
    take_ack = tk; exc_ret = ex;
    @(negedge clk);
    take_ack = 1'b0; exc_ret = 1'b0;
  endtask

  task automatic expect_irq(input bit er, input int el, input int ed, input string tag);
    @(negedge clk);
    #2;
    chk(irq_req == er, {tag, " irq_req"}, irq_req, er);
    if (er) chk(int'(irq_line) == el, {tag, " irq_line"}, irq_line, el);
    chk(int'(nest_depth) == ed, {tag, " nest_depth"}, nest_depth, ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1;

    // R1: reset state
    rd_chk(8'h00, 32'h0, "R1 enable word0");
    rd_chk(8'h11, 32'h0, "R1 pending word1");
    rd_chk(8'h2E, 32'h0, "R1 priority word");
    rd_chk(8'h40, 32'h0, "R1 control word");
    expect_irq(0, 0, 0, "R1");

    // R4: upper nibble kept, lower nibble reads 0
    wr(8'h21, 32'hF7A5_3C1B);
    rd_chk(8'h21, 32'hF0A0_3010, "R4 priority nibbles");
    wr(8'h22, 32'h0050_0000);
    wr(8'h28, 32'h0000_0050);
    wr(8'h2E, 32'h3000_0000);
    rd_chk(8'h2E, 32'h3000_0000, "R4 line59 byte");

    // R2: enable set/clear, readback from both addresses
    wr(8'h00, 32'h0000_0410);
    wr(8'h01, 32'hF800_0001);
    rd_chk(8'h01, 32'h0800_0001, "R2 set word1 unimplemented bits");
    rd_chk(8'h09, 32'h0800_0001, "R2 clear word1 readback");
    wr(8'h08, 32'h0000_0010);
    rd_chk(8'h00, 32'h0000_0400, "R2 clear line4");

    // R3, R6: pending; line 4 is disabled with the best priority
    wr(8'h10, 32'h0000_0410);
    wr(8'h11, 32'h0000_0001);
    rd_chk(8'h18, 32'h0000_0410, "R3 pending via clear addr");
    expect_irq(1, 10, 0, "R6 tie lowest line, disabled ignored");

    // R9, R7: take line 10; line 32 at equal preemption must wait
    pulse(1, 0);
    expect_irq(0, 0, 1, "R7 equal preemption blocked");
    rd_chk(8'h10, 32'h0000_0010, "R9 taken pending cleared");

    wr(8'h11, 32'h0800_0000);
    expect_irq(1, 59, 1, "R7 higher preemption requests");

    // R5: key guard
    wr(8'h40, 32'h1234_0700);
    rd_chk(8'h40, 32'h0, "R5 wrong key ignored");
    expect_irq(1, 59, 1, "R5 grouping unchanged");
    wr(8'h40, 32'h05FA_0700);
    rd_chk(8'h40, 32'h0000_0700, "R5 keyed write");

    // R8: regrouping reinterprets stack and winner
    expect_irq(0, 0, 1, "R8 all-sub grouping blocks");
    wr(8'h40, 32'h05FA_0500);
    expect_irq(1, 59, 1, "R8 two-bit split preempts");

    // R9: take with return in the same cycle only pops
    pulse(1, 1);
    expect_irq(1, 59, 0, "R9 simultaneous take and return");
    rd_chk(8'h11, 32'h0800_0001, "R9 pending kept on simultaneous");
    pulse(1, 0);
    expect_irq(0, 0, 1, "R9 push after take");
    rd_chk(8'h11, 32'h0000_0001, "R9 line59 pending cleared");
    pulse(0, 1);
    expect_irq(1, 32, 0, "R9 pop");
    pulse(0, 1);
    expect_irq(1, 32, 0, "R9 return on empty ignored");

    // R10: take without request
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h19, 32'hFFFF_FFFF);
    pulse(1, 0);
    expect_irq(0, 0, 0, "R10 ack without request");
    rd_chk(8'h11, 32'h0, "R10 pending unchanged");

    // Random phase against the model.
    for (int n = 0; n < 6000; n++) begin
      int sel;
      logic [7:0] a;
      logic [31:0] d;
      @(negedge clk);
      sel = int'($urandom % 12);
      case (sel)
        0, 1:  a = 8'h00 + 8'($urandom % 2);
        2:     a = 8'h08 + 8'($urandom % 2);
        3, 4:  a = 8'h10 + 8'($urandom % 2);
        5:     a = 8'h18 + 8'($urandom % 2);
        6, 7:  a = 8'h20 + 8'($urandom % 16);
        8:     a = 8'h40;
        9:     a = 8'h07;
        default: a = 8'h41;
      endcase
      d = $urandom;
      if (sel == 2 || sel == 5) d = d & $urandom & $urandom;
      if (sel == 8 && ($urandom % 2 == 0)) d[31:16] = 16'h05FA;
      bus_wr    = ($urandom % 3 == 0);
      bus_addr  = a;
      bus_wdata = d;
      take_ack  = ($urandom % 3 == 0);
      exc_ret   = ($urandom % 7 == 0);
      #1;
      chk(bus_rdata == m_read(int'(a)), "R2 R3 R4 R5 random readback", bus_rdata, m_read(int'(a)));
    end
    @(negedge clk);
    bus_wr = 1'b0; take_ack = 1'b0; exc_ret = 1'b0;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule